// File: doc/BRIEF.md
# Flash Program Status-Polling Controller

This block is the word-program engine of a small NOR-style flash array, together with the status word that a host reads back while the engine runs. The host uses a simple strobed bus with an address, write data, a read strobe and a write strobe. A program operation takes two writes. The first write carries the arm code, and the second carries the target address and the target data. After that, an internal loop alternates between a program pulse and a verify step. It counts the pulses against a parameterised limit.

A pulse can only clear bits. A target word that needs a bit raised from 0 to 1 can therefore never verify. In that case the engine hits its pulse limit, raises the timing-limit flag, and stays in a failed state until the host writes the reset code. In read mode, reads return array contents. While the engine is busy or failed, reads return the status word. In the status word, bit 7 is the polled data bit, bit 6 is the toggle bit and bit 5 is the timing-limit flag.

Top module: `flash_prog_poll`

## Requirements
- R1: After the active-low reset, every array word reads all ones and the block is in read mode.
- R2: Writing the arm code 0xA0, followed by a write of address A and data D, programs word A. Once finished, reads of A return the old word ANDed with D, which equals D when D only clears bits. The second write is always taken as data, even 0xA0; only 0xF0 is not.
- R3: While programming, a read returns a status word. Bit 7 is the complement of bit 7 of D, bit 5 is 0 and bits 4..0 are 0.
- R4: Status bit 6 inverts on every read strobe while busy or failed, starting from 0 after reset. Reads in read mode never change it and return array data.
- R5: Each pulse stores (stored AND D) into word A, and no other word changes. A D that needs a 0-to-1 change never verifies, and the stored word keeps the old value ANDed with D.
- R6: Let the write of D land on clock edge 0. When verify keeps failing, a status read captured on edge 2*PULSE_LIMIT shows bit 5 = 0. A read captured on any later edge shows bit 5 = 1.
- R7: In the failed state, every read returns status with bit 7 equal to the complement of D bit 7, never the true data bit, and bit 5 = 1.
- R8: While busy or failed, any write other than 0xF0 is ignored.
- R9: A write of 0xF0 returns the block to read mode on the next edge from any state. It clears bit 5 and the pulse count, and it cancels a pulse scheduled for the same edge.
- R10: In read mode, writes other than 0xA0 do not change the array. A program that verifies on its first pulse returns reads of array data from edge 3 on, with status still returned on edges 1 and 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Word address for reads and program data writes |
| bus_wdata | input | DATA_W | Write data or command code |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | DATA_W | Registered read result, array word or status word |

## Verification
A wrong sequencer state appears at the ports on the very next read. A stuck busy state keeps returning status words where array data is expected. A lost failed state drops bit 5, and a wrong toggle register gives two equal bit-6 values on back-to-back polls. Pulse-count errors are caught by the exact edge on which bit 5 first reads 1. A wrong pulse mask appears as a wrong array word on the first read after the operation completes or is reset.

// File: rtl/flash_poll_pkg.sv
// Package: shared state type and command codes for the flash program
// status-polling controller. Assumes command codes fit in 8 bits.
package flash_poll_pkg;

    typedef enum logic [1:0] {
        ST_READ  = 2'd0,
        ST_ARMED = 2'd1,
        ST_BUSY  = 2'd2,
        ST_FAIL  = 2'd3
    } fp_state_e;

    typedef enum logic {
        PH_PULSE  = 1'b0,
        PH_VERIFY = 1'b1
    } fp_phase_e;

    localparam logic [7:0] CMD_ARM   = 8'hA0;
    localparam logic [7:0] CMD_RESET = 8'hF0;

    localparam int STAT_POLL_BIT = 7;
    localparam int STAT_TOG_BIT  = 6;
    localparam int STAT_TLIM_BIT = 5;

endpackage

// File: rtl/flash_cell_array.sv
// Module: word array with clear-only programming.
// Each word is a register bank that resets to all ones (erased). A pulse
// ANDs the pulse data into the addressed word. One combinational read port
// serves the bus and a second one serves the verify step.
// Assumes: DEPTH equals 2**ADDR_W.
module flash_cell_array #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pulse_en,
    input  logic [ADDR_W-1:0] pulse_addr,
    input  logic [DATA_W-1:0] pulse_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] vfy_word
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words [DEPTH];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_word
            // Per-word storage: erase on reset, clear-only update on a pulse.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    words[g] <= '1;
                end else if (pulse_en && (pulse_addr == ADDR_W'(g))) begin
                    words[g] <= words[g] & pulse_data;
                end
            end
        end
    endgenerate

    // Read ports: bus address and sequencer target address.
    always_comb begin
        rd_word  = words[rd_addr];
        vfy_word = words[pulse_addr];
    end

endmodule

// File: rtl/flash_prog_seq.sv
// Module: command decoder and program/verify sequencer.
// Decodes the arm and reset codes, latches the target, alternates pulse and
// verify phases, counts pulses and raises the timing-limit flag at the limit.
// Assumes: bus_wr is a one-cycle strobe; DATA_W >= 8.
module flash_prog_seq
    import flash_poll_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 8,
    parameter int PULSE_LIMIT = 16,
    parameter int CNT_W       = $clog2(PULSE_LIMIT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] vfy_word,
    output fp_state_e         state,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [DATA_W-1:0] tgt_data,
    output logic              pulse_en,
    output logic              tlim,
    output logic [CNT_W-1:0]  pulse_cnt
);
    localparam logic [DATA_W-1:0] ARM_CODE   = DATA_W'(CMD_ARM);
    localparam logic [DATA_W-1:0] RESET_CODE = DATA_W'(CMD_RESET);
    localparam logic [CNT_W-1:0]  CNT_LIMIT  = CNT_W'(PULSE_LIMIT);

    fp_state_e         state_d;
    fp_phase_e         phase_q, phase_d;
    logic [CNT_W-1:0]  cnt_d;
    logic              tlim_d;
    logic [ADDR_W-1:0] tgt_addr_d;
    logic [DATA_W-1:0] tgt_data_d;
    logic              reset_cmd;
    logic              arm_cmd;
    logic              verified;

    // Command decode from the write strobe and data.
    always_comb begin
        reset_cmd = bus_wr && (bus_wdata == RESET_CODE);
        arm_cmd   = bus_wr && (bus_wdata == ARM_CODE);
        verified  = (vfy_word == tgt_data);
    end

    // Pulse request: pulse phase of a busy cycle, cancelled by a reset code.
    always_comb begin
        pulse_en = (state == ST_BUSY) && (phase_q == PH_PULSE) && !reset_cmd;
    end

    // Next-state logic for the sequencer, counter, flag and target latch.
    always_comb begin
        state_d    = state;
        phase_d    = phase_q;
        cnt_d      = pulse_cnt;
        tlim_d     = tlim;
        tgt_addr_d = tgt_addr;
        tgt_data_d = tgt_data;
        if (reset_cmd) begin
            state_d = ST_READ;
            phase_d = PH_PULSE;
            cnt_d   = '0;
            tlim_d  = 1'b0;
        end else begin
            unique case (state)
                ST_READ: begin
                    if (arm_cmd) begin
                        state_d = ST_ARMED;
                    end
                end
                ST_ARMED: begin
                    if (bus_wr) begin
                        state_d    = ST_BUSY;
                        phase_d    = PH_PULSE;
                        cnt_d      = '0;
                        tgt_addr_d = bus_addr;
                        tgt_data_d = bus_wdata;
                    end
                end
                ST_BUSY: begin
                    if (phase_q == PH_PULSE) begin
                        cnt_d   = pulse_cnt + 1'b1;
                        phase_d = PH_VERIFY;
                    end else if (verified) begin
                        state_d = ST_READ;
                        phase_d = PH_PULSE;
                    end else if (pulse_cnt >= CNT_LIMIT) begin
                        state_d = ST_FAIL;
                        tlim_d  = 1'b1;
                    end else begin
                        phase_d = PH_PULSE;
                    end
                end
                ST_FAIL: begin
                    state_d = ST_FAIL;
                end
                default: begin
                    state_d = ST_READ;
                end
            endcase
        end
    end

    // Sequencer registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_READ;
            phase_q   <= PH_PULSE;
            pulse_cnt <= '0;
            tlim      <= 1'b0;
            tgt_addr  <= '0;
            tgt_data  <= '0;
        end else begin
            state     <= state_d;
            phase_q   <= phase_d;
            pulse_cnt <= cnt_d;
            tlim      <= tlim_d;
            tgt_addr  <= tgt_addr_d;
            tgt_data  <= tgt_data_d;
        end
    end

endmodule

// File: rtl/flash_status_mux.sv
// Module: status word builder and registered read port.
// While polling (busy or failed) a read returns the status word and flips the
// toggle bit; otherwise it returns the array word. Read data holds between
// read strobes. Assumes: DATA_W >= 8 so status bits 7..5 exist.
module flash_status_mux
    import flash_poll_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              polling,
    input  logic              tgt_msb,
    input  logic              tlim,
    input  logic [DATA_W-1:0] arr_word,
    output logic [DATA_W-1:0] bus_rdata
);
    logic              tog_q;
    logic [DATA_W-1:0] status_word;

    // Status word assembly: polled data bit, toggle bit, limit flag.
    always_comb begin
        status_word                = '0;
        status_word[STAT_POLL_BIT] = ~tgt_msb;
        status_word[STAT_TOG_BIT]  = tog_q;
        status_word[STAT_TLIM_BIT] = tlim;
    end

    // Read register and toggle bit, updated only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog_q     <= 1'b0;
            bus_rdata <= '0;
        end else if (bus_rd) begin
            if (polling) begin
                bus_rdata <= status_word;
                tog_q     <= ~tog_q;
            end else begin
                bus_rdata <= arr_word;
            end
        end
    end

endmodule

// File: rtl/flash_prog_poll.sv
// Module: top of the flash program status-polling controller.
// Connects the sequencer, the clear-only array and the status/read port.
// Assumes: single-cycle read and write strobes, never both in one cycle.
module flash_prog_poll
    import flash_poll_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 8,
    parameter int PULSE_LIMIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int CNT_W = $clog2(PULSE_LIMIT + 1);

    fp_state_e         st;
    logic [ADDR_W-1:0] tgt_addr;
    logic [DATA_W-1:0] tgt_data;
    logic              pulse_en;
    logic              tlim;
    logic [CNT_W-1:0]  pulse_cnt;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] vfy_word;
    logic              polling;

    // Poll mode whenever the engine is running or has failed.
    always_comb begin
        polling = (st == ST_BUSY) || (st == ST_FAIL);
    end

    flash_prog_seq #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .PULSE_LIMIT(PULSE_LIMIT),
        .CNT_W      (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .vfy_word (vfy_word),
        .state    (st),
        .tgt_addr (tgt_addr),
        .tgt_data (tgt_data),
        .pulse_en (pulse_en),
        .tlim     (tlim),
        .pulse_cnt(pulse_cnt)
    );

    flash_cell_array #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .pulse_en  (pulse_en),
        .pulse_addr(tgt_addr),
        .pulse_data(tgt_data),
        .rd_addr   (bus_addr),
        .rd_word   (rd_word),
        .vfy_word  (vfy_word)
    );

    flash_status_mux #(
        .DATA_W(DATA_W)
    ) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_rd   (bus_rd),
        .polling  (polling),
        .tgt_msb  (tgt_data[STAT_POLL_BIT]),
        .tlim     (tlim),
        .arr_word (rd_word),
        .bus_rdata(bus_rdata)
    );

endmodule

// File: rtl/flash_prog_poll_chk.sv
// Checker: temporal properties of the sequencer, bound into the top module.
module flash_prog_poll_chk
    import flash_poll_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int PULSE_LIMIT = 16,
    parameter int CNT_W       = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input fp_state_e         st,
    input logic              tlim,
    input logic              pulse_en,
    input logic [CNT_W-1:0]  pulse_cnt
);
    localparam logic [DATA_W-1:0] RESET_CODE = DATA_W'(CMD_RESET);
    localparam logic [CNT_W-1:0]  CNT_LIMIT  = CNT_W'(PULSE_LIMIT);

    AST_TLIM_MATCHES_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        tlim == (st == ST_FAIL)); // R6

    AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_cnt <= CNT_LIMIT); // R6

    AST_TLIM_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tlim) |-> (pulse_cnt == CNT_LIMIT)); // R6

    AST_PULSE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_en |-> (st == ST_BUSY)); // R5

    AST_RESET_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_wdata == RESET_CODE) |=> (st == ST_READ && !tlim && pulse_cnt == '0)); // R9

    AST_FAIL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FAIL && !(bus_wr && bus_wdata == RESET_CODE)) |=> (st == ST_FAIL)); // R8

endmodule

bind flash_prog_poll flash_prog_poll_chk #(
    .DATA_W     (DATA_W),
    .PULSE_LIMIT(PULSE_LIMIT),
    .CNT_W      (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .st       (st),
    .tlim     (tlim),
    .pulse_en (pulse_en),
    .pulse_cnt(pulse_cnt)
);

// File: tb/tb_flash_prog_poll.sv
`timescale 1ns/1ps
module tb_flash_prog_poll;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;
    localparam int LIMIT  = 16;
    localparam int NVEC   = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic              bus_rd = 1'b0;
    logic              bus_wr = 1'b0;
    logic [DATA_W-1:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    bit exp_tog = 1'b0;
    logic [DATA_W-1:0] got;

    // {addr, program data, expected word afterwards}
    localparam logic [19:0] VEC [NVEC] = '{
        {4'd1,  8'h5A, 8'h5A},
        {4'd1,  8'h48, 8'h48},
        {4'd2,  8'h00, 8'h00},
        {4'd4,  8'hA0, 8'hA0},
        {4'd8,  8'h7E, 8'h7E},
        {4'd15, 8'h01, 8'h01}
    };

    always #4 clk = ~clk;

    flash_prog_poll #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PULSE_LIMIT(LIMIT)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata)
    );

    task automatic check(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        got = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [DATA_W-1:0] stat(input logic dmsb, input bit tg, input bit tl);
        return {~dmsb, tg, tl, 5'b0};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1: erased after reset
        rd(4'd0);  check("R1", got, 8'hFF);
        rd(4'd15); check("R1", got, 8'hFF);

        // R10: plain write in read mode ignored
        wr(4'd3, 8'h00); idle(2);
        rd(4'd3); check("R10", got, 8'hFF);

        // Vector table: program, poll once, read back
        for (int v = 0; v < NVEC; v++) begin
            wr(4'd0, 8'hA0);
            wr(VEC[v][19:16], VEC[v][15:8]);
            rd(VEC[v][19:16]);
            check("R3", got, stat(VEC[v][15], exp_tog, 1'b0));
            exp_tog = ~exp_tog;
            idle(3);
            rd(VEC[v][19:16]); check("R2", got, VEC[v][7:0]);
        end

        // R10: status on edges 1 and 2, data from edge 3
        wr(4'd0, 8'hA0);
        wr(4'd9, 8'h11);
        idle(1);
        rd(4'd9); check("R10", got, stat(1'b0, exp_tog, 1'b0)); exp_tog = ~exp_tog;
        rd(4'd9); check("R10", got, 8'h11);
        rd(4'd9); check("R4", got, 8'h11);

        // Failure: word 1 holds 0x48, target 0xFF needs 0-to-1 changes
        wr(4'd0, 8'hA0);
        wr(4'd1, 8'hFF);
        idle(2 * LIMIT - 1);
        rd(4'd1); check("R6", got, stat(1'b1, exp_tog, 1'b0)); exp_tog = ~exp_tog;
        rd(4'd1); check("R6", got, stat(1'b1, exp_tog, 1'b1)); exp_tog = ~exp_tog;
        idle(10);
        rd(4'd1); check("R7", got, stat(1'b1, exp_tog, 1'b1)); exp_tog = ~exp_tog;
        rd(4'd1); check("R4", got, stat(1'b1, exp_tog, 1'b1)); exp_tog = ~exp_tog;
        wr(4'd1, 8'hA0);
        wr(4'd1, 8'h00);
        rd(4'd1); check("R8", got, stat(1'b1, exp_tog, 1'b1)); exp_tog = ~exp_tog;
        wr(4'd0, 8'hF0);
        rd(4'd1); check("R5", got, 8'h48);
        rd(4'd1); check("R9", got, 8'h48);

        // R9: reset on the first pulse edge cancels that pulse
        wr(4'd0, 8'hA0);
        wr(4'd5, 8'h0F);
        wr(4'd0, 8'hF0);
        idle(2);
        rd(4'd5); check("R9", got, 8'hFF);

        // R9: reset while armed, then a plain write is ignored
        wr(4'd0, 8'hA0);
        wr(4'd0, 8'hF0);
        wr(4'd7, 8'h00); idle(2);
        rd(4'd7); check("R9", got, 8'hFF);

        // R8: data write during busy ignored; R5: other words untouched
        wr(4'd0, 8'hA0);
        wr(4'd6, 8'h3C);
        wr(4'd6, 8'h00);
        idle(3);
        rd(4'd6); check("R8", got, 8'h3C);
        rd(4'd2); check("R5", got, 8'h00);
        rd(4'd10); check("R5", got, 8'hFF);

        // R1: reset mid-run erases the array again
        rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(1);
        rd(4'd6); check("R1", got, 8'hFF);
        exp_tog = 1'b0;
        wr(4'd0, 8'hA0);
        wr(4'd6, 8'h80);
        rd(4'd6); check("R4", got, stat(1'b1, exp_tog, 1'b0));

        idle(4);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule